// File: doc/BRIEF.md
# Chained Block Address Generator

This block produces the sequence of memory addresses for one channel transfer. The address is split in two parts. The upper part is a block number, and the lower part is an offset inside that block. Each advance strobe moves the offset on by one. When the offset rolls over to zero, the upper part does not carry. Instead, it takes a block number that was loaded beforehand into a small chain register. This lets a single transfer continue into a memory block that is not next to the current one. The chain register also holds a flag. If the flag is set, a one-cycle interrupt pulse is raised when the jump happens. If it is clear, the jump is silent.

Software loads the start address, then loads the chain register with the next block and its flag. The chain register may be written again at any time during the transfer, so it is ready for the following boundary. A two-state machine tracks whether a chain entry is waiting:

- `CH_EMPTY`: no entry is waiting. A wrap in this state leaves the block number alone.
- `CH_ARMED`: an entry is waiting.

The transitions between the two states are:

- LOAD: `CH_EMPTY` to `CH_ARMED`, on a chain load.
- RELOAD: `CH_ARMED` to `CH_ARMED`, on a chain load.
- CONSUME: `CH_ARMED` to `CH_EMPTY`, on a wrap with no chain load in the same cycle.
- HOLD: stay in the same state when none of the above applies.

Top module: `chain_addr_gen`

## Requirements
- R1: After reset, `cur_addr` is 0, `chain_irq` is 0, and no chain entry is waiting. A wrap right after reset therefore keeps block 0.
- R2: When `advance` is high and `start_load` is low, the address changes on the next clock edge. The offset (bits 10..0) goes up by one. The block number (bits 15..11) is unchanged unless the offset rolls over.
- R3: When `start_load` is high, the next value of `cur_addr` is `start_addr`, even if `advance` is high in the same cycle. Loading the start address does not change the waiting chain entry.
- R4: A high `chain_load` stores `chain_flag` and `chain_block` and marks the entry as waiting. Writing it again before a wrap replaces the entry, and the last write is the one used.
- R5: An advance whose offset rolls over from 2047 while an entry is waiting has three effects. The offset becomes 0. The block number becomes the stored `chain_block`. The entry is consumed, so it stops waiting.
- R6: An advance whose offset rolls over while no entry is waiting sets the offset to 0 and keeps the block number unchanged.
- R7: If the consumed entry's flag is 1, `chain_irq` is high for exactly one cycle. That cycle is the one in which the new block number first shows on `cur_addr`.
- R8: If the consumed entry's flag is 0, `chain_irq` stays low.
- R9: If `chain_load` is high in the same cycle as a rollover, the rollover uses the entry stored before that cycle. The newly loaded entry stays waiting for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_load | input | 1 | Load `start_addr` into the address register |
| start_addr | input | 16 | Start address: block in bits 15..11, offset in bits 10..0 |
| advance | input | 1 | Step the offset by one |
| chain_load | input | 1 | Write the chain entry |
| chain_flag | input | 1 | Interrupt flag for the chain entry |
| chain_block | input | 5 | Next block number for the chain entry |
| cur_addr | output | 16 | Current memory address |
| chain_irq | output | 1 | One-cycle pulse when a flagged chain jump takes place |

## Verification
Several properties are checked on every cycle:

- loading the start address and its priority over a step;
- the offset step when no rollover happens;
- the block replacement and pulse on a rollover while an entry waits;
- the unchanged block on a rollover with no entry;
- the single-cycle width of the pulse.

Other behaviour only shows across sequences in the bench. This covers which of several reloads is the one used. It also covers an entry consumed once and then not reused, a load in the same cycle as a rollover, and a start load that leaves a waiting entry in place.

// File: rtl/chain_addr_pkg.sv
package chain_addr_pkg;
    typedef enum logic {
        CH_EMPTY = 1'b0,
        CH_ARMED = 1'b1
    } chain_st_t;
endpackage

// File: rtl/chain_addr_reg.sv
module chain_addr_reg #(
    parameter int OFS_W = 11,
    parameter int BLK_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [OFS_W+BLK_W-1:0] load_val,
    input  logic                   step,
    input  logic                   swap,
    input  logic [BLK_W-1:0]       swap_blk,
    output logic [OFS_W+BLK_W-1:0] addr_q,
    output logic                   wrap
);
    logic [OFS_W-1:0] ofs_q;
    logic [BLK_W-1:0] blk_q;

    // A step from the all-ones offset rolls over; a start load overrides it
    assign wrap   = step && !load_en && (&ofs_q);
    assign addr_q = {blk_q, ofs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
            blk_q <= '0;
        end else if (load_en) begin
            {blk_q, ofs_q} <= load_val;
        end else if (step) begin
            ofs_q <= ofs_q + 1'b1;
            if (swap) begin
                blk_q <= swap_blk;
            end
        end
    end
endmodule

// File: rtl/chain_ctl.sv
module chain_ctl
    import chain_addr_pkg::*;
#(
    parameter int BLK_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             ld_flag,
    input  logic [BLK_W-1:0] ld_blk,
    input  logic             wrap,
    output logic             swap,
    output logic [BLK_W-1:0] held_blk,
    output logic             held_flag,
    output logic             armed,
    output logic             irq
);
    chain_st_t        state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic             flag_q;
    logic             irq_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_EMPTY: if (ld) state_d = CH_ARMED;                   // LOAD
            CH_ARMED: if (wrap && !ld) state_d = CH_EMPTY;          // CONSUME
            default:  state_d = CH_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_EMPTY;
        else        state_q <= state_d;
    end

    assign swap      = (state_q == CH_ARMED) && wrap;
    assign held_blk  = blk_q;
    assign held_flag = flag_q;
    assign armed     = (state_q == CH_ARMED);
    assign irq       = irq_q;

    // Output and entry registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= '0;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= swap && flag_q;
            if (ld) begin
                blk_q  <= ld_blk;
                flag_q <= ld_flag;
            end
        end
    end
endmodule

// File: rtl/chain_addr_gen.sv
module chain_addr_gen #(
    parameter int OFS_W = 11,
    parameter int BLK_W = 5,
    localparam int AW   = OFS_W + BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_load,
    input  logic [AW-1:0]    start_addr,
    input  logic             advance,
    input  logic             chain_load,
    input  logic             chain_flag,
    input  logic [BLK_W-1:0] chain_block,
    output logic [AW-1:0]    cur_addr,
    output logic             chain_irq
);
    logic             wrap;
    logic             swap;
    logic [BLK_W-1:0] held_blk;
    logic             held_flag;
    logic             armed;

    chain_addr_reg #(.OFS_W(OFS_W), .BLK_W(BLK_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (start_load),
        .load_val (start_addr),
        .step     (advance),
        .swap     (swap),
        .swap_blk (held_blk),
        .addr_q   (cur_addr),
        .wrap     (wrap)
    );

    chain_ctl #(.BLK_W(BLK_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (chain_load),
        .ld_flag   (chain_flag),
        .ld_blk    (chain_block),
        .wrap      (wrap),
        .swap      (swap),
        .held_blk  (held_blk),
        .held_flag (held_flag),
        .armed     (armed),
        .irq       (chain_irq)
    );
endmodule

// File: rtl/chain_addr_chk.sv
module chain_addr_chk #(
    parameter int OFS_W = 11,
    parameter int BLK_W = 5,
    localparam int AW   = OFS_W + BLK_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_load,
    input logic [AW-1:0]    start_addr,
    input logic             advance,
    input logic [AW-1:0]    cur_addr,
    input logic             chain_irq,
    input logic             armed,
    input logic [BLK_W-1:0] held_blk,
    input logic             held_flag
);
    logic roll;
    assign roll = advance && !start_load && (&cur_addr[OFS_W-1:0]);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> cur_addr == $past(start_addr)); // R3

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !start_load && !(&cur_addr[OFS_W-1:0])) |=>
        (cur_addr[OFS_W-1:0] == $past(cur_addr[OFS_W-1:0]) + 1'b1) &&
        (cur_addr[AW-1:OFS_W] == $past(cur_addr[AW-1:OFS_W]))); // R2

    AST_CHAIN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && armed) |=> (cur_addr[OFS_W-1:0] == '0) &&
        (cur_addr[AW-1:OFS_W] == $past(held_blk)) &&
        (chain_irq == $past(held_flag))); // R5

    AST_NO_CHAIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && !armed) |=> (cur_addr[OFS_W-1:0] == '0) &&
        (cur_addr[AW-1:OFS_W] == $past(cur_addr[AW-1:OFS_W])) && !chain_irq); // R6

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_irq |=> !chain_irq); // R7

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        chain_irq |-> (cur_addr[OFS_W-1:0] == '0)); // R7
endmodule

bind chain_addr_gen chain_addr_chk #(.OFS_W(OFS_W), .BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_load (start_load),
    .start_addr (start_addr),
    .advance    (advance),
    .cur_addr   (cur_addr),
    .chain_irq  (chain_irq),
    .armed      (armed),
    .held_blk   (held_blk),
    .held_flag  (held_flag)
);

// File: tb/sim_chain_addr_gen.sv
`timescale 1ns/1ps
module sim_chain_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_load = 1'b0;
    logic [15:0] start_addr = '0;
    logic        advance = 1'b0;
    logic        chain_load = 1'b0;
    logic        chain_flag = 1'b0;
    logic [4:0]  chain_block = '0;
    logic [15:0] cur_addr;
    logic        chain_irq;

    int checks = 0;
    int errors = 0;
    int seed   = 1234;

    // Reference model state
    logic [15:0] m_addr;
    logic        m_irq, m_valid, m_flag;
    logic [4:0]  m_blk;

    always #2.5 clk = ~clk;

    chain_addr_gen u0 (.*);

    // Next address according to R2, R3, R5, R6
    function automatic logic [15:0] next_addr(input logic [15:0] a, input logic sl,
            input logic [15:0] sa, input logic adv, input logic v, input logic [4:0] b);
        if (sl) return sa;
        if (!adv) return a;
        if (a[10:0] == 11'h7FF) return {(v ? b : a[15:11]), 11'h000};
        return {a[15:11], a[10:0] + 11'd1};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, compare after the rising edge
    task automatic cyc(input logic sl, input logic [15:0] sa, input logic adv,
                       input logic cl, input logic cf, input logic [4:0] cb, input string tag);
        logic roll;
        @(negedge clk);
        start_load = sl; start_addr = sa; advance = adv;
        chain_load = cl; chain_flag = cf; chain_block = cb;
        roll = !sl && adv && (m_addr[10:0] == 11'h7FF);
        @(posedge clk);
        m_addr = next_addr(m_addr, sl, sa, adv, m_valid, m_blk);
        m_irq  = roll && m_valid && m_flag;
        if (roll && m_valid) m_valid = 1'b0;
        if (cl) begin m_valid = 1'b1; m_flag = cf; m_blk = cb; end
        #1;
        chk({tag, " addr"}, 32'(cur_addr), 32'(m_addr));
        chk({tag, " irq"}, 32'(chain_irq), 32'(m_irq));
        start_load = 1'b0; advance = 1'b0; chain_load = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_addr = '0; m_irq = 0; m_valid = 0; m_flag = 0; m_blk = '0;
        #12 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset addr", 32'(cur_addr), 0);
        chk("R1 reset irq", 32'(chain_irq), 0);
        // R1: no entry waiting, so a rollover keeps block 0
        cyc(1, 16'h07FF, 0, 0, 0, 0, "R1 setup");
        cyc(0, 0, 1, 0, 0, 0, "R1 R6 wrap after reset");
        // R2: plain steps
        cyc(1, 16'h5A10, 0, 0, 0, 0, "R3 load");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, "R2 step");
        // R3: start load wins over an advance
        cyc(1, 16'h1234, 1, 0, 0, 0, "R3 priority");
        // R4 and R5 and R7: reload, and the last write is used
        cyc(0, 0, 0, 1, 0, 5'd3, "R4 first load");
        cyc(0, 0, 0, 1, 1, 5'd17, "R4 reload");
        cyc(1, 16'h47FE, 0, 0, 0, 0, "R3 keeps entry");
        cyc(0, 0, 1, 0, 0, 0, "R2 pre-wrap");
        cyc(0, 0, 1, 0, 0, 0, "R5 R7 flagged jump");
        cyc(0, 0, 1, 0, 0, 0, "R7 pulse ends");
        // The entry was consumed: the next rollover keeps the block (R6)
        cyc(1, 16'h8FFF, 0, 0, 0, 0, "R3 load");
        cyc(0, 0, 1, 0, 0, 0, "R6 consumed entry");
        // R8: flag clear gives a silent jump
        cyc(0, 0, 0, 1, 0, 5'd9, "R8 load");
        cyc(1, 16'h27FF, 0, 0, 0, 0, "R3 load");
        cyc(0, 0, 1, 0, 0, 0, "R8 silent jump");
        // R9: load in the same cycle as a rollover
        cyc(0, 0, 0, 1, 1, 5'd6, "R9 first entry");
        cyc(1, 16'hF7FF, 0, 0, 0, 0, "R3 load");
        cyc(0, 0, 1, 1, 0, 5'd20, "R9 load on wrap uses old");
        cyc(1, 16'h07FF, 0, 0, 0, 0, "R3 load");
        cyc(0, 0, 1, 0, 0, 0, "R9 new entry used");
        // Random mix; loads near the boundary to reach rollovers
        for (int i = 0; i < 4000; i++) begin
            logic sl, adv, cl, cf;
            logic [15:0] sa;
            logic [4:0] cb;
            sl  = ($urandom(seed) % 40) == 0;
            seed = seed + 1;
            sa  = {5'($urandom()), 11'h7F0 | 11'($urandom() % 16)};
            adv = ($urandom() % 4) != 0;
            cl  = ($urandom() % 25) == 0;
            cf  = 1'($urandom());
            cb  = 5'($urandom());
            cyc(sl, sa, adv, cl, cf, cb, "R2 R5 R6 R7 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule